// File: doc/BRIEF.md
# Oscillator Stop Control with Active-Source Interlock

This block holds the run/stop control for three clock sources: a high-speed external oscillator (or external clock input), a low-speed sub-system oscillator, and an on-die high-speed oscillator. Software reaches the block through one 8-bit register on a simple bus with address, write enable, write data and combinational read data. Each source has a registered stop output that goes straight to its oscillator cell.

Two live status inputs report which source feeds the CPU/peripheral clock. The block refuses any write that would halt the source now in use. A refused stop leaves its bit unchanged and sets a sticky error flag. The block also ignores all register writes until the clock mode register, which lives elsewhere, has been written at least once since reset. That event is signalled by a one-cycle strobe.

Top module: `osc_stop_ctrl`

## Requirements
- R1: After reset the register reads 0xC0, `extStop`=1, `subStop`=1, `hiStop`=0 and `blockErr`=0; reset is the only thing that clears `blockErr`.
- R2: Register layout: bit 7 controls the high-speed external source, bit 6 the sub-system source and bit 0 the on-die high-speed source. In each bit, 1 means stop and 0 means run. Bits 5..1 always read 0, whatever is written to them.
- R3: A register write is ignored unless `modeWrPulse` was high in some earlier cycle since reset; a write in the same cycle as the first pulse is ignored.
- R4: Setting bit 7 takes effect only while `selSubClk`=1 or `mainIsExt`=0.
- R5: Setting bit 6 takes effect only while `selSubClk`=0.
- R6: Setting bit 0 takes effect only while `selSubClk`=1 or `mainIsExt`=1.
- R7: A refused stop request leaves that bit at its previous value and sets `blockErr`, which then stays 1; the other bits of the same write still apply.
- R8: Writing 0 to a stop bit is always accepted once the gate of R3 is open.
- R9: Writes at any address other than `REG_ADDR` change nothing, and reads there return 0x00.
- R10: The stop outputs and `blockErr` are registered: they change on the first rising clock edge that samples an accepted write, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register bus address |
| busWe | input | 1 | Write enable for a full 8-bit write |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from address |
| modeWrPulse | input | 1 | One-cycle strobe: the clock mode register was written |
| selSubClk | input | 1 | 1 when the CPU clock comes from the sub-system source |
| mainIsExt | input | 1 | 1 when the main clock is the high-speed external source, 0 when it is the on-die one |
| extStop | output | 1 | Stop to the high-speed external oscillator |
| subStop | output | 1 | Stop to the sub-system oscillator |
| hiStop | output | 1 | Stop to the on-die high-speed oscillator |
| blockErr | output | 1 | Sticky flag: a stop request was refused |

## Verification
A write presented before a rising edge shows its effect on the stop outputs, the error flag and the read data just after that edge, one cycle of latency. Read data for a given address is valid in the same cycle, with no latency. The bench drives every input on the falling edge. In that same half cycle it first confirms the old state is still present, to cover R10. It then samples again on the next falling edge, after exactly one rising edge. The enable gate is tested by pulsing the mode strobe in the very cycle of a write and checking that this write is still ignored.

// File: rtl/osc_stop_pkg.sv
package osc_stop_pkg;
  localparam int NUM_SRC = 3;
  localparam int SRC_EXT = 0;
  localparam int SRC_SUB = 1;
  localparam int SRC_HI  = 2;
  localparam int DATA_W  = 8;
  // reset: external and sub-system stopped, on-die running
  localparam logic [NUM_SRC-1:0] STOP_RESET = 3'b011;

  typedef struct packed {
    logic [NUM_SRC-1:0] load;
    logic               errSet;
  } stop_strobe_t;

  // register bit that carries the stop control of each source
  function automatic int bitPos(input int src);
    case (src)
      SRC_EXT: return 7;
      SRC_SUB: return 6;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/osc_stop_ctrl_unit.sv
module osc_stop_ctrl_unit
  import osc_stop_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h21
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic               modeWrPulse,
  input  logic               selSubClk,
  input  logic               mainIsExt,
  input  logic [NUM_SRC-1:0] stopState,
  output logic               addrHit,
  output stop_strobe_t       strobe
);
  logic cfgDoneQ;
  logic acceptWr;
  logic [NUM_SRC-1:0] allow;
  logic [NUM_SRC-1:0] blocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cfgDoneQ <= 1'b0;
    else if (modeWrPulse) cfgDoneQ <= 1'b1;
  end

  assign addrHit  = (busAddr == REG_ADDR);
  assign acceptWr = busWe && addrHit && cfgDoneQ;

  // a source may be stopped only while it is not the CPU clock
  always_comb begin
    allow[SRC_EXT] = selSubClk || !mainIsExt;
    allow[SRC_SUB] = !selSubClk;
    allow[SRC_HI]  = selSubClk || mainIsExt;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int POS = bitPos(i);
    assign blocked[i]     = acceptWr && busWdata[POS] && !allow[i] && !stopState[i];
    assign strobe.load[i] = acceptWr && !blocked[i];
  end

  assign strobe.errSet = |blocked;

  assert_write_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    !cfgDoneQ |=> $stable(stopState));
  assert_ext_interlock_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopState[SRC_EXT]) |-> $past(selSubClk || !mainIsExt));
  assert_sub_interlock_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopState[SRC_SUB]) |-> $past(!selSubClk));
  assert_hi_interlock_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopState[SRC_HI]) |-> $past(selSubClk || mainIsExt));
  assert_start_accepted_R8: assert property (@(posedge clk) disable iff (!rstN)
    (acceptWr && !busWdata[bitPos(SRC_EXT)]) |=> !stopState[SRC_EXT]);
endmodule

// File: rtl/osc_stop_datapath.sv
module osc_stop_datapath
  import osc_stop_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  stop_strobe_t       strobe,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic               addrHit,
  output logic [NUM_SRC-1:0] stopQ,
  output logic               errQ,
  output logic [DATA_W-1:0]  busRdata
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    localparam int POS = bitPos(i);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               stopQ[i] <= STOP_RESET[i];
      else if (strobe.load[i]) stopQ[i] <= busWdata[POS];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              errQ <= 1'b0;
    else if (strobe.errSet) errQ <= 1'b1;
  end

  always_comb begin
    busRdata = '0;
    if (addrHit) begin
      for (int i = 0; i < NUM_SRC; i++) busRdata[bitPos(i)] = stopQ[i];
    end
  end

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> errQ);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[5:1] == '0);
  assert_miss_reads_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !addrHit |-> busRdata == '0);
  assert_change_on_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(stopQ) |-> $past(|strobe.load));
endmodule

// File: rtl/osc_stop_ctrl.sv
module osc_stop_ctrl
  import osc_stop_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              modeWrPulse,
  input  logic              selSubClk,
  input  logic              mainIsExt,
  output logic              extStop,
  output logic              subStop,
  output logic              hiStop,
  output logic              blockErr
);
  stop_strobe_t       strobe;
  logic               addrHit;
  logic [NUM_SRC-1:0] stopQ;

  osc_stop_ctrl_unit #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .modeWrPulse(modeWrPulse), .selSubClk(selSubClk),
    .mainIsExt(mainIsExt), .stopState(stopQ), .addrHit(addrHit), .strobe(strobe)
  );

  osc_stop_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .addrHit(addrHit), .stopQ(stopQ), .errQ(blockErr), .busRdata(busRdata)
  );

  assign extStop = stopQ[SRC_EXT];
  assign subStop = stopQ[SRC_SUB];
  assign hiStop  = stopQ[SRC_HI];

  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rstN) |-> (extStop && subStop && !hiStop && !blockErr));
endmodule

// File: tb/osc_stop_ctrl_tb.sv
module osc_stop_ctrl_tb;
  localparam logic [7:0] REG_A   = 8'h21;
  localparam logic [7:0] OTHER_A = 8'h22;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = REG_A;
  logic busWe = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic modeWrPulse = 1'b0;
  logic selSubClk = 1'b0;
  logic mainIsExt = 1'b0;
  logic extStop, subStop, hiStop, blockErr;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  osc_stop_ctrl #(.ADDR_W(8), .REG_ADDR(REG_A)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .modeWrPulse(modeWrPulse),
    .selSubClk(selSubClk), .mainIsExt(mainIsExt), .extStop(extStop),
    .subStop(subStop), .hiStop(hiStop), .blockErr(blockErr)
  );

  task automatic checkState(input logic [7:0] expReg, input logic expErr, input string req);
    logic [7:0] outs;
    busAddr = REG_A;
    #1;
    outs = {extStop, subStop, 5'b0, hiStop};
    checks++;
    if (busRdata !== expReg || outs !== expReg || blockErr !== expErr) begin
      errors++;
      $display("FAIL %s: rdata=%h outs=%h err=%b expected reg=%h err=%b",
               req, busRdata, outs, blockErr, expReg, expErr);
    end
  endtask

  // drive on falling edge, hold across one rising edge, release on next falling edge
  task automatic busWrite(input logic [7:0] addr, input logic [7:0] data, input logic modePulse);
    @(negedge clk);
    busAddr = addr; busWdata = data; busWe = 1'b1; modeWrPulse = modePulse;
    @(negedge clk);
    busWe = 1'b0; modeWrPulse = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    checkState(8'hC0, 1'b0, "R1 reset value");
  endtask

  task automatic testGate();
    busWrite(REG_A, 8'h00, 1'b0);
    checkState(8'hC0, 1'b0, "R3 write before mode write");
    busWrite(REG_A, 8'h00, 1'b1);
    checkState(8'hC0, 1'b0, "R3 write in same cycle as first mode pulse");
  endtask

  task automatic testStartAndTiming();
    selSubClk = 1'b0; mainIsExt = 1'b0;
    @(negedge clk);
    busAddr = REG_A; busWdata = 8'h00; busWe = 1'b1;
    #1;
    checks++;
    if (extStop !== 1'b1 || subStop !== 1'b1) begin
      errors++;
      $display("FAIL R10: outputs moved before edge ext=%b sub=%b expected 1 1", extStop, subStop);
    end
    @(negedge clk);
    busWe = 1'b0;
    checkState(8'h00, 1'b0, "R8 R10 start all sources");
  endtask

  task automatic testOtherAddr();
    busWrite(OTHER_A, 8'hFF, 1'b0);
    busAddr = OTHER_A;
    #1;
    checks++;
    if (busRdata !== 8'h00) begin
      errors++;
      $display("FAIL R9: other-address read=%h expected 00", busRdata);
    end
    checkState(8'h00, 1'b0, "R9 other-address write ignored");
  endtask

  task automatic testInterlocks();
    // CPU on on-die main clock
    busWrite(REG_A, 8'h01, 1'b0);
    checkState(8'h00, 1'b1, "R6 R7 on-die stop refused while in use");
    mainIsExt = 1'b1;
    busWrite(REG_A, 8'h80, 1'b0);
    checkState(8'h00, 1'b1, "R4 external stop refused while in use");
    busWrite(REG_A, 8'h01, 1'b0);
    checkState(8'h01, 1'b1, "R6 on-die stop honoured on external main");
    selSubClk = 1'b1;
    busWrite(REG_A, 8'h40, 1'b0);
    checkState(8'h00, 1'b1, "R5 R7 sub stop refused, on-die restart applies");
    busWrite(REG_A, 8'h81, 1'b0);
    checkState(8'h81, 1'b1, "R4 R6 external and on-die stop on sub clock");
    selSubClk = 1'b0; mainIsExt = 1'b0;
    busWrite(REG_A, 8'h00, 1'b0);
    checkState(8'h00, 1'b1, "R8 restart both");
    busWrite(REG_A, 8'hC0, 1'b0);
    checkState(8'hC0, 1'b1, "R4 R5 stop external and sub on on-die main");
    busWrite(REG_A, 8'h3E, 1'b0);
    checkState(8'h00, 1'b1, "R2 reserved bits read zero");
  endtask

  task automatic testErrClear();
    doReset();
    checkState(8'hC0, 1'b0, "R1 reset clears sticky error");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGate();
    testStartAndTiming();
    testOtherAddr();
    testInterlocks();
    testErrClear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule